// File: doc/BRIEF.md
# Reset Mode Latch with Guarded Configuration Registers

This block fixes the chip's operating mode from two strap pins while reset is held. The value present on the last clock edge before reset is released is the one that counts. It also holds two registers that software reaches through a small read/write port.

The first register combines the mode and the interrupt priority. It carries three mode flags and a five-bit priority field, and each of the three flags follows its own write rule. The second register is a configuration shadow. It is loaded from a nonvolatile byte during reset and can be overwritten directly only while the chip is in a special mode.

Downstream logic takes the latched mode, the live special-mode flag and the configuration bits straight from the outputs. Programming the nonvolatile cells is handled elsewhere. So is the priority logic that consumes the priority field.

Top module: `mode_cfg_latch`

## Requirements
- R1: The mode code on `op_mode` equals {mode_b_pin, mode_a_pin} as sampled during reset: 2'b10 is single chip, 2'b11 is expanded, 2'b00 is bootstrap and 2'b01 is special test.
- R2: After reset the mode register reads $06 in single chip, $26 in expanded, $C6 in bootstrap and $66 in special test. Bit 7 is the boot-ROM enable, bit 6 is the special flag and bit 5 is the mode-A flag. The special flag also drives `special_flag`.
- R3: A write can clear the special flag (bit 6) but can never set it.
- R4: While the special flag is 1, the mode-A flag (bit 5) takes every written value. While the special flag is 0, only the first write to the mode register changes bit 5, and later writes leave it unchanged.
- R5: The boot-ROM enable (bit 7) takes the written value only when the special flag is 1 before the write. Otherwise bit 7 is left unchanged.
- R6: The priority field (bits 4:0) resets to 5'b00110 and takes every written value.
- R7: The configuration register is loaded from `nv_cfg` while reset is held. Changes on `nv_cfg` after reset do not show until the next reset.
- R8: A configuration write lands in the register when the special flag is 1 and is ignored when the special flag is 0.
- R9: Configuration bits that are not implemented (bit 6 with the default mask 8'hBF) always read 1, on both `rd_data` and `cfg_bits`.
- R10: Pin changes after reset release leave `op_mode` unchanged.
- R11: `rd_data` shows the mode register when `reg_sel` is 0 and the configuration register when `reg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the mode pins and `nv_cfg` are sampled while it is low |
| mode_b_pin | input | 1 | Mode strap pin B |
| mode_a_pin | input | 1 | Mode strap pin A |
| reg_sel | input | 1 | Register select: 0 selects the mode register, 1 selects the configuration register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| nv_cfg | input | 8 | Nonvolatile configuration byte |
| op_mode | output | 2 | Latched mode code |
| special_flag | output | 1 | Current special-mode flag |
| cfg_bits | output | 8 | Working configuration bits, with unimplemented bits forced to 1 |

## Verification
The hardest state to reach is the change from special to normal mode. Only the special flag (bit 6) decides whether a write reaches the boot-ROM enable (bit 7) or the configuration register. That flag can fall but never rise. A single write with bit 6 clear therefore permanently closes those paths, and it also starts the write-once count for the mode-A flag (bit 5).

The stimulus reaches each of these states in turn, starting from every one of the four reset modes. It first sweeps all 256 configuration values while the special flag is still set. It then sweeps the mode register downward from $FF, so the first 64 writes run in special mode before a write with bit 6 clear ends it. A final configuration sweep confirms that the configuration register is now frozen.

// File: rtl/mlatch_pkg.sv
package mlatch_pkg;
  localparam int DATA_W    = 8;
  localparam int PRI_W     = 5;
  localparam int BOOT_BIT  = 7;
  localparam int SPEC_BIT  = 6;
  localparam int MA_BIT    = 5;
  localparam logic [PRI_W-1:0] PRI_RESET = 5'b00110;

  typedef enum logic [1:0] {
    OPM_BOOT     = 2'b00,
    OPM_TEST     = 2'b01,
    OPM_SINGLE   = 2'b10,
    OPM_EXPANDED = 2'b11
  } opmode_e;

  // Register value loaded at reset for a given strap code.
  function automatic logic [DATA_W-1:0] mode_reset_word(input opmode_e m);
    logic [DATA_W-1:0] w;
    w                = '0;
    w[PRI_W-1:0]     = PRI_RESET;
    w[MA_BIT]        = m[0];
    w[SPEC_BIT]      = ~m[1];
    w[BOOT_BIT]      = (m == OPM_BOOT);
    return w;
  endfunction

  // Next mode register value for a write, given the old value and lock state.
  function automatic logic [DATA_W-1:0] mode_write(input logic [DATA_W-1:0] old,
                                                   input logic locked,
                                                   input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] n;
    n              = old;
    n[PRI_W-1:0]   = d[PRI_W-1:0];
    if (old[SPEC_BIT]) begin
      n[BOOT_BIT]  = d[BOOT_BIT];
      n[MA_BIT]    = d[MA_BIT];
    end else if (!locked) begin
      n[MA_BIT]    = d[MA_BIT];
    end
    n[SPEC_BIT]    = old[SPEC_BIT] & d[SPEC_BIT];
    return n;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_view(input logic [DATA_W-1:0] latch,
                                                 input logic [DATA_W-1:0] impl);
    return latch | ~impl;
  endfunction
endpackage

// File: rtl/mode_pin_latch.sv
module mode_pin_latch
  import mlatch_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opmode_e pin_code,
  output opmode_e mode_q
);
  // Follows the pins on every clock while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= pin_code;
  end
endmodule

// File: rtl/mode_prio_reg.sv
module mode_prio_reg
  import mlatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  opmode_e           pin_code,
  input  logic              wr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] word_q,
  output logic              ma_locked_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q      <= mode_reset_word(pin_code);
      ma_locked_q <= 1'b0;
    end else if (wr) begin
      word_q <= mode_write(word_q, ma_locked_q, wd);
      if (!word_q[SPEC_BIT]) ma_locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_shadow_reg.sv
module cfg_shadow_reg
  import mlatch_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] nv_byte,
  input  logic              special_i,
  input  logic              wr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] view_o
);
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                latch_q <= nv_byte;
    else if (wr && special_i)  latch_q <= wd;
  end

  assign view_o = cfg_view(latch_q, IMPL_MASK);
endmodule

// File: rtl/mode_cfg_latch.sv
module mode_cfg_latch
  import mlatch_pkg::*;
#(
  parameter logic [7:0] CFG_IMPL_MASK = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_b_pin,
  input  logic       mode_a_pin,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] nv_cfg,
  output logic [1:0] op_mode,
  output logic       special_flag,
  output logic [7:0] cfg_bits
);
  opmode_e           pin_code;
  opmode_e           mode_q;
  logic [DATA_W-1:0] mode_word;
  logic              ma_locked;
  logic              wr_mode;
  logic              wr_cfg;

  assign pin_code = opmode_e'({mode_b_pin, mode_a_pin});
  assign wr_mode  = wr_en & ~reg_sel;
  assign wr_cfg   = wr_en &  reg_sel;

  mode_pin_latch u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_code (pin_code),
    .mode_q   (mode_q)
  );

  mode_prio_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_code    (pin_code),
    .wr          (wr_mode),
    .wd          (wr_data),
    .word_q      (mode_word),
    .ma_locked_q (ma_locked)
  );

  cfg_shadow_reg #(.IMPL_MASK(CFG_IMPL_MASK)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_byte   (nv_cfg),
    .special_i (mode_word[SPEC_BIT]),
    .wr        (wr_cfg),
    .wd        (wr_data),
    .view_o    (cfg_bits)
  );

  assign op_mode      = mode_q;
  assign special_flag = mode_word[SPEC_BIT];
  assign rd_data      = reg_sel ? cfg_bits : mode_word;
endmodule

// File: rtl/mode_cfg_latch_chk.sv
module mode_cfg_latch_chk #(
  parameter logic [7:0] IMPL_MASK = 8'hBF
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_mode,
  input logic       special_flag,
  input logic [7:0] cfg_bits,
  input logic [7:0] mode_word,
  input logic       ma_locked
);
  AST_OPMODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(op_mode)); // R10

  AST_SPECIAL_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$rose(special_flag)); // R3

  AST_CFG_FROZEN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(special_flag)) |-> $stable(cfg_bits)); // R8

  AST_UNIMPL_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits | IMPL_MASK) == 8'hFF); // R9

  AST_BOOT_FROZEN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(special_flag)) |-> $stable(mode_word[7])); // R5

  AST_MA_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(special_flag) && $past(ma_locked)) |-> $stable(mode_word[5])); // R4
endmodule

bind mode_cfg_latch mode_cfg_latch_chk #(.IMPL_MASK(CFG_IMPL_MASK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_mode      (op_mode),
  .special_flag (special_flag),
  .cfg_bits     (cfg_bits),
  .mode_word    (mode_word),
  .ma_locked    (ma_locked)
);

// File: tb/tb_mode_cfg_latch.sv
module tb_mode_cfg_latch;
  localparam logic [7:0] IMPL = 8'hBF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_b_pin = 1'b0, mode_a_pin = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, nv_cfg = '0;
  logic [7:0] rd_data, cfg_bits;
  logic [1:0] op_mode;
  logic       special_flag;

  int errs = 0, checks = 0;

  // model state
  logic       m_boot, m_spec, m_ma, m_lock;
  logic [4:0] m_pri;
  logic [7:0] m_cfg;

  mode_cfg_latch dut (
    .clk(clk), .rst_n(rst_n), .mode_b_pin(mode_b_pin), .mode_a_pin(mode_a_pin),
    .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .nv_cfg(nv_cfg), .op_mode(op_mode), .special_flag(special_flag), .cfg_bits(cfg_bits)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic b, input logic a, input logic [7:0] nv);
    @(negedge clk);
    rst_n = 1'b0; mode_b_pin = b; mode_a_pin = a; nv_cfg = nv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_mode_reg(input string ctx);
    reg_sel = 1'b0; #1;
    chk({"R5 boot bit ", ctx}, {7'd0, rd_data[7]}, {7'd0, m_boot});
    chk({"R3 special bit ", ctx}, {7'd0, rd_data[6]}, {7'd0, m_spec});
    chk({"R3 special_flag ", ctx}, {7'd0, special_flag}, {7'd0, m_spec});
    chk({"R4 mode-A bit ", ctx}, {7'd0, rd_data[5]}, {7'd0, m_ma});
    chk({"R6 priority ", ctx}, {3'd0, rd_data[4:0]}, {3'd0, m_pri});
  endtask

  task automatic check_cfg(input string ctx);
    reg_sel = 1'b1; #1;
    chk({"R11 cfg read ", ctx}, rd_data, m_cfg);
    chk({"R9 cfg_bits ", ctx}, cfg_bits, m_cfg);
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int mi = 0; mi < 4; mi++) begin
      logic b, a;
      logic [7:0] nv, exp_rst;
      b  = mi[1]; a = mi[0];
      nv = 8'(mi * 8'h55);
      do_reset(b, a, nv);
      // expected reset contents, R2: boot=128 only for 00, special=64 when b=0, A=32
      exp_rst = 8'((((!b) && (!a)) ? 128 : 0) + ((!b) ? 64 : 0) + (a ? 32 : 0) + 6);
      m_boot = exp_rst[7]; m_spec = exp_rst[6]; m_ma = exp_rst[5];
      m_pri = 5'd6; m_lock = 1'b0;
      m_cfg = nv | ~IMPL;

      chk("R1 op_mode after reset", {6'd0, op_mode}, {6'd0, b, a});
      reg_sel = 1'b0; #1;
      chk("R2 mode reg reset value", rd_data, exp_rst);
      chk("R6 priority reset", {3'd0, rd_data[4:0]}, 8'h06);
      check_cfg("R7 after reset");

      // R10/R7: pin and nv changes after reset are not visible
      @(negedge clk);
      mode_b_pin = ~b; mode_a_pin = ~a; nv_cfg = ~nv;
      repeat (3) @(negedge clk);
      chk("R10 op_mode frozen", {6'd0, op_mode}, {6'd0, b, a});
      check_cfg("R7 nv change ignored");
      check_mode_reg("R2 after pin change");

      // R8: config sweep (special modes take writes, normal modes ignore them)
      for (int d = 0; d < 256; d++) begin
        wr(1'b1, 8'(d));
        if (m_spec) m_cfg = 8'(d) | ~IMPL;
        check_cfg("R8 sweep");
      end

      // mode register sweep downward from FF
      for (int d = 255; d >= 0; d--) begin
        logic [7:0] dv;
        dv = 8'(d);
        wr(1'b0, dv);
        if (m_spec) begin
          m_boot = dv[7]; m_ma = dv[5];
        end else begin
          if (!m_lock) m_ma = dv[5];
          m_lock = 1'b1;
        end
        if (!dv[6]) m_spec = 1'b0;
        m_pri = dv[4:0];
        check_mode_reg("sweep");
      end

      // special flag now clear: config writes ignored
      chk("R3 special cleared after sweep", {7'd0, special_flag}, 8'd0);
      for (int d = 0; d < 16; d++) begin
        wr(1'b1, 8'(d * 17));
        check_cfg("R8 normal ignored");
      end
      chk("R10 op_mode end of pass", {6'd0, op_mode}, {6'd0, b, a});
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule